// File: doc/BRIEF.md
# Speculation token register file

This block is a general-purpose register file in which every register carries one extra poison bit, here called the token. A load issued ahead of its guarding branch may hit a fault. Such a load writes the token of its destination and does not trap. Any later computation that reads a poisoned register passes the poison on to its own destination. A check operation then asks the file whether a register is poisoned. If it is, the file pulses a redirect output, and the front end uses it to branch to recovery code. Because poison follows every dependent result, one check on the last value of a chain catches a fault in any earlier link.

The file has two combinational read ports, which return data and token. It has one ALU writeback port and one load writeback port. The ALU writeback port carries the numbers of the operation's source registers and a mask of the sources it actually used. The file merges the tokens of those sources, taken from its own contents in the writeback cycle. The load port carries a speculative flag and a fault flag. The check port takes a register number and returns a registered redirect pulse together with that number.

Reads return the contents as they stood before the current clock edge. A write is visible on the cycle after it is made, and nothing is forwarded within the same cycle.

Top module: `spec_regfile`

## Requirements
- R1: After a synchronous reset, every register reads as zero with a clear token, and the redirect output is low.
- R2: A value written at a clock edge appears on the read ports from that edge on. During the cycle in which a write is presented, a read of the same register returns the older contents, with no same-cycle bypass.
- R3: Register 0 always reads zero with a clear token. Writes to it from either port are dropped, and a check on it never redirects.
- R4: A load with both the speculative flag and the fault flag set writes zero data and sets the destination token, and raises no other output.
- R5: A load that is not speculative, whatever its fault flag, and a speculative load without a fault both write their data and clear the destination token. This clears a token left by an earlier faulted load.
- R6: An ALU writeback stores its data. It sets the destination token to the OR of the tokens of those sources whose bit in the use mask is 1 (bit 0 selects source 0, bit 1 selects source 1), read as the file held them before that edge. Sources whose mask bit is 0 have no effect.
- R7: When both ports write the same register at one edge, the load's data and token are kept. When they target different registers, both writes take effect.
- R8: A check on a register whose token is set drives redirect high for exactly the one cycle after the check, with redirect index equal to the checked register number. The redirect index is zero whenever redirect is low.
- R9: A check on a register with a clear token leaves redirect low.
- R10: Poison from a faulted load reaches the end of a chain of dependent ALU operations, so a single check on the chain's final register redirects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 7 | Read port A register number |
| rd_a_data | output | 64 | Read port A data |
| rd_a_tok | output | 1 | Read port A token |
| rd_b_idx | input | 7 | Read port B register number |
| rd_b_data | output | 64 | Read port B data |
| rd_b_tok | output | 1 | Read port B token |
| alu_we | input | 1 | ALU writeback valid |
| alu_dst | input | 7 | ALU destination register |
| alu_src0 | input | 7 | First source register of the operation |
| alu_src1 | input | 7 | Second source register of the operation |
| alu_src_use | input | 2 | Source use mask, bit 0 for source 0, bit 1 for source 1 |
| alu_data | input | 64 | ALU result |
| ld_we | input | 1 | Load writeback valid |
| ld_dst | input | 7 | Load destination register |
| ld_data | input | 64 | Load data |
| ld_spec | input | 1 | Load was issued speculatively |
| ld_fault | input | 1 | Load hit a fault |
| chk_valid | input | 1 | Check operation valid |
| chk_idx | input | 7 | Register to check |
| redir | output | 1 | Redirect-to-recovery pulse |
| redir_idx | output | 7 | Register whose check caused the redirect |

## Verification
On every cycle the assertions cover the behaviour of register 0 and the redirect output. They check that redirect stays low just after reset and that every redirect pulse matches a check from the cycle before and names a nonzero register. They also check that a load result, faulted or clean and whether or not it collides with an ALU write, shows up on the next cycle, and that an ALU result with an empty use mask comes back clean. Token merging across several sources, the spread of poison through multi-step chains, the lack of a same-cycle bypass, and a clean load clearing an old token depend on history longer than one cycle. Only the bench's directed scenarios and its per-cycle reference model, running against random traffic over a small set of registers, show those.

// File: rtl/spec_rf_pkg.sv
package spec_rf_pkg;

    localparam int RF_XLEN  = 64;
    localparam int RF_NREGS = 128;
    localparam int RF_NSRC  = 2;
    localparam int RF_NWR   = 2;

    // write slot numbering; the load slot is applied last
    localparam int SLOT_ALU  = 0;
    localparam int SLOT_LOAD = 1;

    typedef enum logic [1:0] {
        LDK_NONE  = 2'd0,
        LDK_CLEAN = 2'd1,
        LDK_POISON = 2'd2
    } ld_kind_e;

    typedef struct packed {
        logic spec;
        logic fault;
    } ld_attr_t;

    function automatic ld_kind_e ld_classify(logic valid, ld_attr_t a);
        if (!valid)               return LDK_NONE;
        else if (a.spec && a.fault) return LDK_POISON;
        else                      return LDK_CLEAN;
    endfunction

    function automatic logic src_merge(logic [RF_NSRC-1:0] tok,
                                       logic [RF_NSRC-1:0] use_m);
        return |(tok & use_m);
    endfunction

endpackage

// File: rtl/spec_rf_wsel.sv
module spec_rf_wsel
    import spec_rf_pkg::*;
#(
    parameter int XLEN  = RF_XLEN,
    parameter int IDX_W = 7,
    parameter int NSRC  = RF_NSRC
) (
    input  logic                          alu_we,
    input  logic [IDX_W-1:0]              alu_dst,
    input  logic [XLEN-1:0]               alu_data,
    input  logic [NSRC-1:0]               alu_src_tok,
    input  logic [NSRC-1:0]               alu_src_use,
    input  logic                          ld_we,
    input  logic [IDX_W-1:0]              ld_dst,
    input  logic [XLEN-1:0]               ld_data,
    input  ld_attr_t                      ld_attr,
    output logic [RF_NWR-1:0]             wr_en,
    output logic [RF_NWR-1:0][IDX_W-1:0]  wr_idx,
    output logic [RF_NWR-1:0][XLEN-1:0]   wr_data,
    output logic [RF_NWR-1:0]             wr_tok
);

    ld_kind_e kind;
    logic     ld_live;
    logic     alu_live;

    always_comb begin
        kind     = ld_classify(ld_we, ld_attr);
        ld_live  = (kind != LDK_NONE) && (ld_dst != '0);
        alu_live = alu_we && (alu_dst != '0) && !(ld_live && (ld_dst == alu_dst));

        wr_en[SLOT_LOAD]   = ld_live;
        wr_idx[SLOT_LOAD]  = ld_dst;
        wr_data[SLOT_LOAD] = (kind == LDK_POISON) ? '0 : ld_data;
        wr_tok[SLOT_LOAD]  = (kind == LDK_POISON);

        wr_en[SLOT_ALU]    = alu_live;
        wr_idx[SLOT_ALU]   = alu_dst;
        wr_data[SLOT_ALU]  = alu_data;
        wr_tok[SLOT_ALU]   = src_merge(alu_src_tok, alu_src_use);
    end

endmodule

// File: rtl/spec_rf_store.sv
module spec_rf_store #(
    parameter int NREGS = 128,
    parameter int XLEN  = 64,
    parameter int IDX_W = $clog2(NREGS),
    parameter int NWR   = 2,
    parameter int NRD   = 2,
    parameter int NTK   = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NWR-1:0]              wr_en,
    input  logic [NWR-1:0][IDX_W-1:0]   wr_idx,
    input  logic [NWR-1:0][XLEN-1:0]    wr_data,
    input  logic [NWR-1:0]              wr_tok,
    input  logic [NRD-1:0][IDX_W-1:0]   rd_idx,
    output logic [NRD-1:0][XLEN-1:0]    rd_data,
    output logic [NRD-1:0]              rd_tok,
    input  logic [NTK-1:0][IDX_W-1:0]   tk_idx,
    output logic [NTK-1:0]              tk_val
);

    logic [XLEN-1:0] cell_d [NREGS];
    logic            cell_t [NREGS];

    // later slots override earlier ones on the same register
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREGS; r++) begin
                cell_d[r] <= '0;
                cell_t[r] <= 1'b0;
            end
        end else begin
            for (int w = 0; w < NWR; w++) begin
                if (wr_en[w] && (wr_idx[w] != '0)) begin
                    cell_d[wr_idx[w]] <= wr_data[w];
                    cell_t[wr_idx[w]] <= wr_tok[w];
                end
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = (rd_idx[p] == '0) ? '0   : cell_d[rd_idx[p]];
        assign rd_tok[p]  = (rd_idx[p] == '0) ? 1'b0 : cell_t[rd_idx[p]];
    end

    for (genvar q = 0; q < NTK; q++) begin : g_tk
        assign tk_val[q] = (tk_idx[q] == '0) ? 1'b0 : cell_t[tk_idx[q]];
    end

endmodule

// File: rtl/spec_rf_chk_unit.sv
module spec_rf_chk_unit #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chk_valid,
    input  logic [IDX_W-1:0] chk_idx,
    input  logic             chk_tok,
    output logic             redir,
    output logic [IDX_W-1:0] redir_idx
);

    logic fire;

    assign fire = chk_valid && chk_tok;

    always_ff @(posedge clk) begin
        if (rst) begin
            redir     <= 1'b0;
            redir_idx <= '0;
        end else begin
            redir     <= fire;
            redir_idx <= fire ? chk_idx : '0;
        end
    end

endmodule

// File: rtl/spec_regfile.sv
module spec_regfile
    import spec_rf_pkg::*;
#(
    parameter int NREGS = RF_NREGS,
    parameter int XLEN  = RF_XLEN,
    parameter int IDX_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_a_idx,
    output logic [XLEN-1:0]  rd_a_data,
    output logic             rd_a_tok,
    input  logic [IDX_W-1:0] rd_b_idx,
    output logic [XLEN-1:0]  rd_b_data,
    output logic             rd_b_tok,
    input  logic             alu_we,
    input  logic [IDX_W-1:0] alu_dst,
    input  logic [IDX_W-1:0] alu_src0,
    input  logic [IDX_W-1:0] alu_src1,
    input  logic [1:0]       alu_src_use,
    input  logic [XLEN-1:0]  alu_data,
    input  logic             ld_we,
    input  logic [IDX_W-1:0] ld_dst,
    input  logic [XLEN-1:0]  ld_data,
    input  logic             ld_spec,
    input  logic             ld_fault,
    input  logic             chk_valid,
    input  logic [IDX_W-1:0] chk_idx,
    output logic             redir,
    output logic [IDX_W-1:0] redir_idx
);

    localparam int NRD    = 2;
    localparam int NTK    = RF_NSRC + 1;
    localparam int TK_CHK = RF_NSRC;

    logic [RF_NWR-1:0]             wr_en;
    logic [RF_NWR-1:0][IDX_W-1:0]  wr_idx;
    logic [RF_NWR-1:0][XLEN-1:0]   wr_data;
    logic [RF_NWR-1:0]             wr_tok;
    logic [NRD-1:0][IDX_W-1:0]     rd_idx;
    logic [NRD-1:0][XLEN-1:0]      rd_data;
    logic [NRD-1:0]                rd_tok;
    logic [NTK-1:0][IDX_W-1:0]     tk_idx;
    logic [NTK-1:0]                tk_val;
    ld_attr_t                      ld_attr;

    assign rd_idx    = {rd_b_idx, rd_a_idx};
    assign rd_a_data = rd_data[0];
    assign rd_b_data = rd_data[1];
    assign rd_a_tok  = rd_tok[0];
    assign rd_b_tok  = rd_tok[1];
    assign tk_idx    = {chk_idx, alu_src1, alu_src0};
    assign ld_attr   = '{spec: ld_spec, fault: ld_fault};

    spec_rf_wsel #(
        .XLEN  (XLEN),
        .IDX_W (IDX_W),
        .NSRC  (RF_NSRC)
    ) u_wsel (
        .alu_we      (alu_we),
        .alu_dst     (alu_dst),
        .alu_data    (alu_data),
        .alu_src_tok (tk_val[RF_NSRC-1:0]),
        .alu_src_use (alu_src_use),
        .ld_we       (ld_we),
        .ld_dst      (ld_dst),
        .ld_data     (ld_data),
        .ld_attr     (ld_attr),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .wr_tok      (wr_tok)
    );

    spec_rf_store #(
        .NREGS (NREGS),
        .XLEN  (XLEN),
        .IDX_W (IDX_W),
        .NWR   (RF_NWR),
        .NRD   (NRD),
        .NTK   (NTK)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .wr_tok  (wr_tok),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .rd_tok  (rd_tok),
        .tk_idx  (tk_idx),
        .tk_val  (tk_val)
    );

    spec_rf_chk_unit #(
        .IDX_W (IDX_W)
    ) u_chk_unit (
        .clk       (clk),
        .rst       (rst),
        .chk_valid (chk_valid),
        .chk_idx   (chk_idx),
        .chk_tok   (tk_val[TK_CHK]),
        .redir     (redir),
        .redir_idx (redir_idx)
    );

endmodule

// File: rtl/spec_regfile_chk.sv
module spec_regfile_chk #(
    parameter int XLEN  = 64,
    parameter int IDX_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic [IDX_W-1:0] rd_a_idx,
    input logic [XLEN-1:0]  rd_a_data,
    input logic             rd_a_tok,
    input logic [IDX_W-1:0] rd_b_idx,
    input logic [XLEN-1:0]  rd_b_data,
    input logic             rd_b_tok,
    input logic             alu_we,
    input logic [IDX_W-1:0] alu_dst,
    input logic [1:0]       alu_src_use,
    input logic [XLEN-1:0]  alu_data,
    input logic             ld_we,
    input logic [IDX_W-1:0] ld_dst,
    input logic [XLEN-1:0]  ld_data,
    input logic             ld_spec,
    input logic             ld_fault,
    input logic             chk_valid,
    input logic [IDX_W-1:0] chk_idx,
    input logic             redir,
    input logic [IDX_W-1:0] redir_idx
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !redir);

    // R3
    zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == '0) |-> (rd_a_data == '0 && !rd_a_tok));

    // R4
    poison_load_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && ld_we && ld_spec && ld_fault && ld_dst != '0)
         && rd_a_idx == $past(ld_dst))
        |-> (rd_a_tok && rd_a_data == '0));

    // R5
    clean_load_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && ld_we && !(ld_spec && ld_fault) && ld_dst != '0)
         && rd_a_idx == $past(ld_dst))
        |-> (!rd_a_tok && rd_a_data == $past(ld_data)));

    // R7
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && ld_we && alu_we && ld_dst == alu_dst && ld_dst != '0)
         && rd_b_idx == $past(ld_dst))
        |-> (rd_b_tok == $past(ld_spec && ld_fault)));

    // R6
    no_src_clean_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && alu_we && alu_dst != '0 && alu_src_use == 2'b00
               && !(ld_we && ld_dst == alu_dst))
         && rd_b_idx == $past(alu_dst))
        |-> (!rd_b_tok && rd_b_data == $past(alu_data)));

    // R8
    redir_origin_chk: assert property (@(posedge clk) disable iff (rst)
        redir |-> ($past(chk_valid) && redir_idx == $past(chk_idx)));

    // R8
    redir_idle_idx_chk: assert property (@(posedge clk) disable iff (rst)
        !redir |-> (redir_idx == '0));

    // R3
    redir_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        redir |-> (redir_idx != '0));

endmodule

bind spec_regfile spec_regfile_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_sva (.*);

// File: tb/tb_spec_regfile.sv
module tb_spec_regfile;

    localparam int XL = 64;
    localparam int IW = 7;
    localparam int NR = 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [IW-1:0] rd_a_idx = '0, rd_b_idx = '0;
    logic [XL-1:0] rd_a_data, rd_b_data;
    logic          rd_a_tok, rd_b_tok;
    logic          alu_we = 1'b0;
    logic [IW-1:0] alu_dst = '0, alu_src0 = '0, alu_src1 = '0;
    logic [1:0]    alu_src_use = '0;
    logic [XL-1:0] alu_data = '0;
    logic          ld_we = 1'b0;
    logic [IW-1:0] ld_dst = '0;
    logic [XL-1:0] ld_data = '0;
    logic          ld_spec = 1'b0, ld_fault = 1'b0;
    logic          chk_valid = 1'b0;
    logic [IW-1:0] chk_idx = '0;
    logic          redir;
    logic [IW-1:0] redir_idx;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    spec_regfile dut (.*);

    // reference model
    logic [XL-1:0] m_d [NR];
    bit            m_t [NR];
    bit            m_redir = 1'b0;
    int            m_ridx = 0;

    always @(posedge clk) begin
        bit t;
        if (rst) begin
            for (int r = 0; r < NR; r++) begin
                m_d[r] = '0;
                m_t[r] = 1'b0;
            end
            m_redir = 1'b0;
            m_ridx  = 0;
        end else begin
            m_redir = chk_valid && m_t[chk_idx];
            m_ridx  = chk_idx;
            t = (alu_src_use[0] && m_t[alu_src0]) || (alu_src_use[1] && m_t[alu_src1]);
            if (alu_we && alu_dst != 0) begin
                m_d[alu_dst] = alu_data;
                m_t[alu_dst] = t;
            end
            if (ld_we && ld_dst != 0) begin
                if (ld_spec && ld_fault) begin
                    m_d[ld_dst] = '0;
                    m_t[ld_dst] = 1'b1;
                end else begin
                    m_d[ld_dst] = ld_data;
                    m_t[ld_dst] = 1'b0;
                end
            end
        end
    end

    task automatic chk(string tag, string what, logic [XL-1:0] act, logic [XL-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model, well clear of both edges
    always @(posedge clk) begin
        #3;
        if (!done) begin
            chk("R2", "model rd_a data", rd_a_data, m_d[rd_a_idx]);
            chk("R2", "model rd_a tok", 64'(rd_a_tok), 64'(m_t[rd_a_idx]));
            chk("R2", "model rd_b data", rd_b_data, m_d[rd_b_idx]);
            chk("R2", "model rd_b tok", 64'(rd_b_tok), 64'(m_t[rd_b_idx]));
            chk("R8", "model redir", 64'(redir), 64'(m_redir));
            if (m_redir) chk("R8", "model redir_idx", 64'(redir_idx), 64'(m_ridx));
        end
    end

    task automatic nxt();
        @(negedge clk);
    endtask

    task automatic idle();
        alu_we = 1'b0; ld_we = 1'b0; chk_valid = 1'b0;
        ld_spec = 1'b0; ld_fault = 1'b0; alu_src_use = '0;
    endtask

    task automatic load(int dst, logic [XL-1:0] d, bit sp, bit ft);
        ld_we = 1'b1; ld_dst = IW'(dst); ld_data = d; ld_spec = sp; ld_fault = ft;
    endtask

    task automatic alu(int dst, int s0, int s1, logic [1:0] um, logic [XL-1:0] d);
        alu_we = 1'b1; alu_dst = IW'(dst); alu_src0 = IW'(s0); alu_src1 = IW'(s1);
        alu_src_use = um; alu_data = d;
    endtask

    task automatic rdchk(string tag, int idx, logic [XL-1:0] ed, bit et);
        rd_a_idx = IW'(idx);
        #1;
        chk(tag, "read data", rd_a_data, ed);
        chk(tag, "read tok", 64'(rd_a_tok), 64'(et));
    endtask

    task automatic check_reg(int idx);
        chk_valid = 1'b1; chk_idx = IW'(idx);
        nxt();
        idle();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual running expected finished");
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) nxt();
        rst = 1'b0;
        nxt();
        // R1 reset state
        rdchk("R1", 1, '0, 1'b0);
        rdchk("R1", 127, '0, 1'b0);
        chk("R1", "redir", 64'(redir), 64'd0);

        // R5 clean and non-speculative loads
        load(5, 64'h1111_2222_3333_4444, 1'b0, 1'b0); nxt(); idle();
        rdchk("R5", 5, 64'h1111_2222_3333_4444, 1'b0);
        load(6, 64'h0BAD_0000_0000_0006, 1'b0, 1'b1); nxt(); idle();
        rdchk("R5", 6, 64'h0BAD_0000_0000_0006, 1'b0);

        // R4 speculative faulting load
        load(7, 64'hDEAD_BEEF_0000_0007, 1'b1, 1'b1); nxt(); idle();
        rdchk("R4", 7, '0, 1'b1);

        // R2 no same-cycle bypass
        load(8, 64'hAAAA_0000_0000_0008, 1'b0, 1'b0);
        rd_b_idx = 8;
        #1;
        chk("R2", "same-cycle rd_b data", rd_b_data, '0);
        nxt(); idle();
        #1;
        chk("R2", "next-cycle rd_b data", rd_b_data, 64'hAAAA_0000_0000_0008);

        // R3 register 0
        load(0, 64'h1234, 1'b1, 1'b1); alu(0, 7, 7, 2'b11, 64'h5678); nxt(); idle();
        rdchk("R3", 0, '0, 1'b0);
        check_reg(0);
        chk("R3", "redir on r0", 64'(redir), 64'd0);

        // R6 token merge
        alu(9, 7, 5, 2'b11, 64'h99); nxt(); idle();
        rdchk("R6", 9, 64'h99, 1'b1);
        alu(10, 7, 5, 2'b10, 64'h10); nxt(); idle();
        rdchk("R6", 10, 64'h10, 1'b0);
        alu(14, 7, 7, 2'b00, 64'h14); nxt(); idle();
        rdchk("R6", 14, 64'h14, 1'b0);
        alu(18, 5, 7, 2'b10, 64'h18); nxt(); idle();
        rdchk("R6", 18, 64'h18, 1'b1);

        // R10 chain of dependent operations
        alu(11, 9, 5, 2'b11, 64'hB1); nxt(); idle();
        alu(12, 6, 11, 2'b11, 64'hC2); nxt(); idle();
        rdchk("R10", 12, 64'hC2, 1'b1);
        check_reg(12);
        chk("R10", "redir", 64'(redir), 64'd1);
        chk("R10", "redir_idx", 64'(redir_idx), 64'd12);

        // R8 pulse on poisoned register
        check_reg(7);
        chk("R8", "redir", 64'(redir), 64'd1);
        chk("R8", "redir_idx", 64'(redir_idx), 64'd7);
        nxt();
        chk("R8", "redir after pulse", 64'(redir), 64'd0);
        chk("R8", "idle redir_idx", 64'(redir_idx), 64'd0);

        // R9 check on clean register
        check_reg(5);
        chk("R9", "redir", 64'(redir), 64'd0);

        // R7 collisions
        load(13, 64'hC0C0, 1'b0, 1'b0); alu(13, 7, 7, 2'b01, 64'hD0D0); nxt(); idle();
        rdchk("R7", 13, 64'hC0C0, 1'b0);
        load(15, 64'hE0E0, 1'b1, 1'b1); alu(15, 5, 5, 2'b00, 64'hF0F0); nxt(); idle();
        rdchk("R7", 15, '0, 1'b1);
        load(16, 64'h1616, 1'b0, 1'b0); alu(17, 7, 7, 2'b01, 64'h1717); nxt(); idle();
        rdchk("R7", 16, 64'h1616, 1'b0);
        rdchk("R7", 17, 64'h1717, 1'b1);

        // R5 clean speculative load clears an old token
        load(7, 64'h7777, 1'b1, 1'b0); nxt(); idle();
        rdchk("R5", 7, 64'h7777, 1'b0);
        check_reg(7);
        chk("R9", "redir after clear", 64'(redir), 64'd0);

        // random traffic over a small register window
        for (int i = 0; i < 3000; i++) begin
            alu_we      = ($urandom_range(0, 2) != 0);
            alu_dst     = IW'($urandom_range(0, 15));
            alu_src0    = IW'($urandom_range(0, 15));
            alu_src1    = IW'($urandom_range(0, 15));
            alu_src_use = 2'($urandom_range(0, 3));
            alu_data    = {$urandom, $urandom};
            ld_we       = ($urandom_range(0, 2) != 0);
            ld_dst      = IW'($urandom_range(0, 15));
            ld_data     = {$urandom, $urandom};
            ld_spec     = 1'($urandom_range(0, 1));
            ld_fault    = 1'($urandom_range(0, 1));
            chk_valid   = 1'($urandom_range(0, 1));
            chk_idx     = IW'($urandom_range(0, 15));
            rd_a_idx    = IW'($urandom_range(0, 15));
            rd_b_idx    = IW'($urandom_range(0, 15));
            nxt();
        end
        idle();
        nxt();
        nxt();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule